// File: doc/BRIEF.md
# Push-Button Debounce Filter

This block turns the noisy level of one mechanical push button into a clean level that software and control logic can trust. The raw contact signal is first re-timed into the local clock domain by a short register chain. A four-state machine then watches the re-timed level. It has two settled states, settled-low and settled-high, and two candidate states, rising and falling. A cycle counter measures how long the input has held the candidate level. The clean output changes only after the input has held that level for a full stability window.

The window is a parameter counted in clock cycles. The default value of 800000 gives 16 ms with a 50 MHz clock. Besides the clean level, the block gives a one-cycle strobe when the button becomes pressed and another when it becomes released. Consuming logic can use these strobes as edge events.

Top module: `key_filter`

## Requirements
- R1: A synchronous reset puts the block in settled-low: cleanOut is 0, and pressPulse and releasePulse are 0 on the first cycle after reset.
- R2: The raw input passes through two register stages before the state machine sees it. With W = WINDOW_CYCLES, a change of rawKey that then holds steady shows on cleanOut right after the (W+3)-th rising edge. The first edge after the change counts as edge 1.
- R3: cleanOut goes from 0 to 1 only after the re-timed input has read 1 on W+1 consecutive clock edges: one edge to enter the rising state, and W more inside it.
- R4: cleanOut goes from 1 to 0 only after the re-timed input has read 0 on W+1 consecutive clock edges: one edge to enter the falling state, and W more inside it.
- R5: While in a candidate state, a return of the re-timed input to the old level sends the machine back to the previous settled state and clears the count. cleanOut does not change and no pulse appears. A 1 seen on only W consecutive edges therefore never raises the output.
- R6: pressPulse is high for exactly one cycle, and only in the first cycle in which cleanOut is 1 after being 0.
- R7: releasePulse is high for exactly one cycle, and only in the first cycle in which cleanOut is 0 after being 1.
- R8: The stability counter advances only in the two candidate states. It is zero in both settled states, and its width is derived from W so that it never passes W-1. So after any length of settled time, a new change still needs the full R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rawKey | input | 1 | Bouncing button level, asynchronous to clk |
| cleanOut | output | 1 | Debounced button level |
| pressPulse | output | 1 | One-cycle strobe when cleanOut rises |
| releasePulse | output | 1 | One-cycle strobe when cleanOut falls |

## Verification
The bench targets the boundary between W and W+1 consecutive samples. A design with an off-by-one in the compare would raise the output after a burst one cycle too short, or would need one cycle too many. It measures the exact edge count from input change to output change. A missing or extra register stage shifts that count. The count is measured again after a long settled interval, which exposes a counter that keeps running while settled. Random bursts with hold times around the window check every cycle against a run-length model. That model catches pulses that last two cycles, pulses of the wrong polarity, and a glitch that changes the output instead of only restarting the count.

// File: rtl/keyfilt_pkg.sv
package keyfilt_pkg;
  // bit 1 of the encoding is the clean level (HIGH and FALL both read 1)
  typedef enum logic [1:0] {
    ST_LOW  = 2'b00,
    ST_RISE = 2'b01,
    ST_HIGH = 2'b11,
    ST_FALL = 2'b10
  } kf_state_e;

  typedef struct packed {
    logic clr;
    logic inc;
  } kf_strobe_t;
endpackage

// File: rtl/keyfilt_sync.sv
module keyfilt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], dIn};
  end

  assign dOut = pipe[STAGES-1];
endmodule

// File: rtl/keyfilt_timer.sv
module keyfilt_timer
  import keyfilt_pkg::*;
#(
  parameter int WINDOW = 800000
) (
  input  logic            clk,
  input  logic            rst,
  input  kf_strobe_t      strobe,
  output logic            cntDone,
  output logic [((WINDOW > 1) ? $clog2(WINDOW) : 1)-1:0] cntVal
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || strobe.clr) cnt <= '0;
    else if (strobe.inc)   cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == LAST);
  assign cntVal  = cnt;

  // R8: control must leave the candidate state instead of counting past the end
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |-> !strobe.inc);
  p_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/keyfilt_ctrl.sv
module keyfilt_ctrl
  import keyfilt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       syncLvl,
  input  logic       cntDone,
  output kf_strobe_t strobe,
  output kf_state_e  state,
  output logic       cleanLvl,
  output logic       press,
  output logic       release_
);
  kf_state_e nextState;

  always_comb begin
    nextState  = state;
    strobe.clr = 1'b1;
    strobe.inc = 1'b0;
    unique case (state)
      ST_LOW:  if (syncLvl) nextState = ST_RISE;
      ST_HIGH: if (!syncLvl) nextState = ST_FALL;
      ST_RISE: begin
        if (!syncLvl)     nextState = ST_LOW;
        else if (cntDone) nextState = ST_HIGH;
        else begin strobe.clr = 1'b0; strobe.inc = 1'b1; end
      end
      ST_FALL: begin
        if (syncLvl)      nextState = ST_HIGH;
        else if (cntDone) nextState = ST_LOW;
        else begin strobe.clr = 1'b0; strobe.inc = 1'b1; end
      end
      default: nextState = ST_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOW;
      press    <= 1'b0;
      release_ <= 1'b0;
    end else begin
      state    <= nextState;
      press    <= (state == ST_RISE) && (nextState == ST_HIGH);
      release_ <= (state == ST_FALL) && (nextState == ST_LOW);
    end
  end

  assign cleanLvl = state[1];

  // R5: a glitch in the rising window falls back to settled-low
  p_glitch_back_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RISE && !syncLvl) |=> (state == ST_LOW));
  p_glitch_back_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FALL && syncLvl) |=> (state == ST_HIGH));
endmodule

// File: rtl/key_filter.sv
module key_filter
  import keyfilt_pkg::*;
#(
  parameter int WINDOW_CYCLES = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic rawKey,
  output logic cleanOut,
  output logic pressPulse,
  output logic releasePulse
);
  localparam int CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;

  logic          syncLvl;
  logic          cntDone;
  logic [CW-1:0] cntVal;
  kf_strobe_t    strobe;
  kf_state_e     state;

  keyfilt_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .dIn(rawKey), .dOut(syncLvl)
  );

  keyfilt_timer #(.WINDOW(WINDOW_CYCLES)) timer_i (
    .clk(clk), .rst(rst), .strobe(strobe), .cntDone(cntDone), .cntVal(cntVal)
  );

  keyfilt_ctrl ctrl_i (
    .clk(clk), .rst(rst), .syncLvl(syncLvl), .cntDone(cntDone),
    .strobe(strobe), .state(state), .cleanLvl(cleanOut),
    .press(pressPulse), .release_(releasePulse)
  );

  // R8: counter rests at zero in both settled states
  p_settled_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW || state == ST_HIGH) |-> (cntVal == '0));
  // R3 / R4: output only moves in the direction of the last sample
  p_rise_on_one_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cleanOut) |-> $past(syncLvl));
  p_fall_on_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cleanOut) |-> !$past(syncLvl));
  // R6 / R7: strobes mark the edge and last one cycle
  p_press_edge_r6: assert property (@(posedge clk) disable iff (rst)
    pressPulse |-> (cleanOut && !$past(cleanOut)));
  p_release_edge_r7: assert property (@(posedge clk) disable iff (rst)
    releasePulse |-> (!cleanOut && $past(cleanOut)));
  p_press_single_r6: assert property (@(posedge clk) disable iff (rst)
    pressPulse |=> !pressPulse);
  p_release_single_r7: assert property (@(posedge clk) disable iff (rst)
    releasePulse |=> !releasePulse);
endmodule

// File: tb/key_filter_tb_top.sv
module key_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 8;
  localparam int SEED       = 32'h1F2E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawKey = 1'b0;
  logic cleanOut, pressPulse, releasePulse;

  int checks = 0;
  int errors = 0;
  bit cmpEn  = 1'b0;
  int pressCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_filter #(.WINDOW_CYCLES(WIN)) dut_i (
    .clk(clk), .rst(rst), .rawKey(rawKey),
    .cleanOut(cleanOut), .pressPulse(pressPulse), .releasePulse(releasePulse)
  );

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int expLatency(int w);
    return w + 3;
  endfunction

  // run-length reference: output flips once the re-timed level has
  // differed from it on WIN+1 consecutive edges
  logic mA = 0, mB = 0, mClean = 0, mPress = 0, mRel = 0;
  int   mRun = 0;
  always @(posedge clk) begin
    logic smp;
    if (rst) begin
      mA = 0; mB = 0; mClean = 0; mRun = 0; mPress = 0; mRel = 0;
    end else begin
      smp = mB; mB = mA; mA = rawKey;
      mPress = 0; mRel = 0;
      if (smp != mClean) begin
        mRun++;
        if (mRun == WIN + 1) begin
          mClean = smp; mRun = 0;
          if (smp) mPress = 1; else mRel = 1;
        end
      end else mRun = 0;
    end
  end

  always @(negedge clk) begin
    if (cmpEn) begin
      chk("R3/R4 clean level vs model", int'(cleanOut), int'(mClean));
      chk("R6 press strobe vs model", int'(pressPulse), int'(mPress));
      chk("R7 release strobe vs model", int'(releasePulse), int'(mRel));
    end
    if (!rst && pressPulse) pressCount++;
  end

  task automatic measure(input logic lvl, output int edges, output int pulses);
    edges = 0; pulses = 0;
    rawKey = lvl;
    while (edges < 100) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (lvl ? pressPulse : releasePulse) pulses++;
      if (cleanOut == lvl) break;
    end
    @(posedge clk); @(negedge clk);
    if (lvl ? pressPulse : releasePulse) pulses++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e, p, base, dummy;
    dummy = $urandom(SEED);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cleanOut after reset", int'(cleanOut), 0);
    chk("R1 pressPulse after reset", int'(pressPulse), 0);
    chk("R1 releasePulse after reset", int'(releasePulse), 0);
    cmpEn = 1'b1;

    // R2 latency and R6 single press pulse
    measure(1'b1, e, p);
    chk("R2 rise latency in edges", e, expLatency(WIN));
    chk("R6 press pulse count", p, 1);
    repeat (5) @(negedge clk);
    // R4 / R7 fall
    measure(1'b0, e, p);
    chk("R4 fall latency in edges", e, expLatency(WIN));
    chk("R7 release pulse count", p, 1);

    // R5 boundary: W samples of 1 is not enough
    repeat (5) @(negedge clk);
    base = pressCount;
    rawKey = 1'b1;
    repeat (WIN) @(negedge clk);
    rawKey = 1'b0;
    repeat (3*WIN) @(negedge clk);
    chk("R5 output after W-sample burst", int'(cleanOut), 0);
    chk("R5 no press after W-sample burst", pressCount - base, 0);
    // R3 boundary: W+1 samples suffice
    rawKey = 1'b1;
    repeat (WIN + 1) @(negedge clk);
    rawKey = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 press after W+1-sample burst", pressCount - base, 1);
    chk("R3 output high after W+1 burst", int'(cleanOut), 1);
    repeat (3*WIN) @(negedge clk);
    chk("R4 output back low", int'(cleanOut), 0);

    // R8 long settled interval then full latency again
    measure(1'b1, e, p);
    repeat (60) @(negedge clk);
    measure(1'b0, e, p);
    chk("R8 fall latency after long settled high", e, expLatency(WIN));
    repeat (60) @(negedge clk);
    measure(1'b1, e, p);
    chk("R8 rise latency after long settled low", e, expLatency(WIN));

    // random bouncing bursts, checked each cycle against the model
    for (int b = 0; b < 500; b++) begin
      rawKey = ~rawKey;
      repeat ($urandom_range(1, 2*WIN + 4)) @(negedge clk);
    end
    repeat (3*WIN) @(negedge clk);
    chk("R3/R4 settled level after random phase", int'(cleanOut), int'(rawKey));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule